// File: doc/BRIEF.md
# UART Receive Character Buffer

This block stores the characters that a UART receiver has deserialized until the bus reads them. Each strobe from the receiver delivers one byte. The bus reads the oldest stored byte through a 32-bit read port. The byte sits in the low eight bits and the upper bits are zero.

A mode input selects how the bytes are stored. With the mode input low, the block uses one holding register. With it high, the block uses a first-in first-out queue whose depth is a parameter. The block reports that data is available with a data-ready flag, and it reports lost or replaced characters with a sticky overrun flag. A clear strobe resets the overrun flag; it stands in for a read of the line status register.

The read port decodes a window of sixteen consecutive 32-bit word addresses. All sixteen addresses reach the same buffer, so a burst of reads drains successive characters.

Top module: `uart_rx_hold`

## Requirements
- R1: After reset, `data_ready` and `overrun` are both 0.
- R2: In single-register mode (`fifo_en`=0), a byte delivered by `rx_strobe` appears on `rd_data[7:0]` with `data_ready`=1 on the next cycle. A read inside the window clears `data_ready`.
- R3: In single-register mode, a second byte that arrives before the first is read replaces the stored byte and sets `overrun`.
- R4: In FIFO mode (`fifo_en`=1), reads return bytes in arrival order. `data_ready` stays 1 while any byte is stored and drops to 0 after the last one is read.
- R5: In FIFO mode with DEPTH bytes stored, a byte that arrives without a read in the same cycle is discarded, the stored bytes are kept unchanged, and `overrun` is set.
- R6: A read pops the buffer only when `bus_addr` falls in one of the sixteen word addresses `BASE`, `BASE`+4, … `BASE`+60. A read at any address outside that range leaves the stored data and `data_ready` unchanged.
- R7: `rd_data[31:8]` is always 0.
- R8: `overrun` stays 1 through reads and new bytes until `ovr_clr` is pulsed. After that pulse it reads 0.
- R9: Any change of `fifo_en` discards all stored bytes. `data_ready` is 0 on the next cycle.
- R10: A read while `data_ready` is 0 has no effect. The next byte received is the one read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 selects FIFO mode, 0 selects single holding register |
| rx_strobe | input | 1 | One-cycle strobe: a received byte is on `rx_byte` |
| rx_byte | input | 8 | Received character |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | AW | Bus byte address |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_data | output | 32 | Oldest stored byte, zero-extended |
| data_ready | output | 1 | At least one byte is stored |
| overrun | output | 1 | Sticky: a character was lost or replaced |

## Verification
In single-register mode, all 256 byte values are passed through the block, which shows that no data bit is stuck or swapped. Back-to-back arrivals separate replacing the stored byte from keeping it. In FIFO mode, a filled queue holds a distinct arithmetic sequence, so reading it back exposes ordering errors, and one extra byte shows whether the overflow byte is dropped. The address sweep reads once at every word offset in the window, which exposes a decode that is too narrow. It then reads just below and just above the window, which exposes a decode that is too wide. Mode toggles with data pending and reads while empty test the flush and underflow behaviour.

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int DEPTH = 16,
  parameter int AW = 12,
  parameter logic [AW-1:0] BASE = 12'h040
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          rx_strobe,
  input  logic [7:0]    rx_byte,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic          ovr_clr,
  output logic [31:0]   rd_data,
  output logic          data_ready,
  output logic          overrun
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int WIN_LSB = 6;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          mode_q;

  wire flush   = fifo_en != mode_q;
  wire hit     = bus_addr[AW-1:WIN_LSB] == BASE[AW-1:WIN_LSB];
  wire pop     = bus_rd && hit && data_ready && !flush;
  wire full    = count == CW'(DEPTH);
  wire push_q  = mode_q && rx_strobe && (!full || pop);
  wire wr_en   = !flush && rx_strobe && (mode_q ? (!full || pop) : 1'b1);
  wire lost    = !flush && rx_strobe && !pop && (mode_q ? full : (count != '0));

  assign data_ready = count != '0;
  assign rd_data    = {24'h0, mem[rptr]};

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (wr_en) mem[mode_q ? wptr : rptr] <= rx_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      mode_q <= fifo_en;
      if (flush) begin
        wptr  <= '0;
        rptr  <= '0;
        count <= '0;
      end else if (mode_q) begin
        if (push_q) wptr <= nxt(wptr);
        if (pop) rptr <= nxt(rptr);
        count <= count + CW'(push_q) - CW'(pop);
      end else begin
        if (rx_strobe) count <= CW'(1);
        else if (pop) count <= '0;
      end
      if (lost) overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R5
  AST_SINGLE_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> count <= CW'(1)); // R3
  AST_FULL_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && fifo_en && full && rx_strobe && !bus_rd) |=> (overrun && full)); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en != mode_q) |=> !data_ready); // R9
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_ready && !rx_strobe && fifo_en == mode_q) |=> !data_ready); // R10
endmodule

// File: tb/uart_rx_hold_test.sv
module uart_rx_hold_test;
  localparam int DEPTH = 16;
  localparam logic [11:0] BASE = 12'h040;

  logic clk = 0, rst_n = 0, fifo_en = 0, rx_strobe = 0, bus_rd = 0, ovr_clr = 0;
  logic [7:0] rx_byte = 0;
  logic [11:0] bus_addr = BASE;
  logic [31:0] rd_data;
  logic data_ready, overrun;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  uart_rx_hold #(.DEPTH(DEPTH), .AW(12), .BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_strobe(rx_strobe),
    .rx_byte(rx_byte), .bus_rd(bus_rd), .bus_addr(bus_addr), .ovr_clr(ovr_clr),
    .rd_data(rd_data), .data_ready(data_ready), .overrun(overrun));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    rx_strobe = 1; rx_byte = b;
    tick;
    rx_strobe = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    #1 d = rd_data;
    tick;
    bus_rd = 0; bus_addr = BASE;
  endtask

  task automatic setmode(input bit m);
    fifo_en = m;
    tick;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0] e;
    repeat (3) tick;
    rst_n = 1;
    tick;
    check(data_ready == 0 && overrun == 0, "R1", {data_ready, overrun}, 0);

    for (int b = 0; b < 256; b++) begin
      push(8'(b));
      check(data_ready == 1, "R2", data_ready, 1);
      rd(BASE, d);
      check(d[7:0] == 8'(b), "R2", d[7:0], b);
      check(d[31:8] == 0, "R7", d[31:8], 0);
      check(data_ready == 0, "R2", data_ready, 0);
    end
    check(overrun == 0, "R3", overrun, 0);

    push(8'h11); push(8'h22);
    check(overrun == 1, "R3", overrun, 1);
    rd(BASE, d);
    check(d[7:0] == 8'h22, "R3", d[7:0], 8'h22);
    check(overrun == 1, "R8", overrun, 1);
    push(8'h44); tick;
    check(overrun == 1, "R8", overrun, 1);
    rd(BASE, d);
    ovr_clr = 1; tick; ovr_clr = 0;
    check(overrun == 0, "R8", overrun, 0);

    rd(BASE, d); rd(BASE, d);
    check(data_ready == 0, "R10", data_ready, 0);
    push(8'h5A); rd(BASE, d);
    check(d[7:0] == 8'h5A, "R10", d[7:0], 8'h5A);

    push(8'h33);
    setmode(1);
    check(data_ready == 0, "R9", data_ready, 0);

    for (int i = 0; i < DEPTH; i++) begin
      push(8'(i * 37 + 5));
      check(data_ready == 1, "R4", data_ready, 1);
    end
    check(overrun == 0, "R5", overrun, 0);
    push(8'hEE);
    check(overrun == 1, "R5", overrun, 1);
    for (int i = 0; i < DEPTH; i++) begin
      e = 8'(i * 37 + 5);
      check(data_ready == 1, "R4", data_ready, 1);
      rd(BASE, d);
      check(d[7:0] == e, "R5", d[7:0], e);
      check(d[31:8] == 0, "R7", d[31:8], 0);
    end
    check(data_ready == 0, "R4", data_ready, 0);
    ovr_clr = 1; tick; ovr_clr = 0;

    for (int i = 0; i < DEPTH; i++) push(8'(200 - i * 3));
    for (int k = 0; k < 16; k++) begin
      e = 8'(200 - k * 3);
      rd(BASE + 12'(4 * k), d);
      check(d[7:0] == e, "R6", d[7:0], e);
    end
    check(data_ready == 0, "R6", data_ready, 0);
    push(8'h91); push(8'h92);
    rd(BASE - 12'd4, d);
    rd(BASE + 12'd64, d);
    rd(12'h000, d);
    check(data_ready == 1, "R6", data_ready, 1);
    rd(BASE + 12'd60, d);
    check(d[7:0] == 8'h91, "R6", d[7:0], 8'h91);
    rd(BASE, d);
    check(d[7:0] == 8'h92, "R6", d[7:0], 8'h92);

    rd(BASE, d); rd(BASE, d);
    check(data_ready == 0, "R10", data_ready, 0);
    push(8'h77);
    rd(BASE, d);
    check(d[7:0] == 8'h77 && data_ready == 0, "R10", d[7:0], 8'h77);
    check(overrun == 0, "R8", overrun, 0);

    push(1); push(2); push(3);
    setmode(0);
    check(data_ready == 0, "R9", data_ready, 0);
    push(8'hC3); rd(BASE, d);
    check(d[7:0] == 8'hC3, "R9", d[7:0], 8'hC3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule